// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns a 64-bit binary floating-point operand into a 32-bit or 64-bit integer, signed or unsigned. It rounds either in the selected rounding mode or, when truncation is requested, toward zero. Along with the integer it reports two flags: one for an inexact result and one for an invalid conversion. It applies a fixed precedence between the two flags. An out-of-range result raises only the invalid flag. An unsigned conversion of a small negative value that rounds to zero raises only the inexact flag.

A controller pulses `go` with the operand and the selects. The block takes a snapshot of everything on that edge and runs through four named states:

- **IDLE**: waiting. The transition *accept* goes to ALIGN when `go` is high.
- **ALIGN**: the operand is unpacked and shifted into an integer part plus guard and sticky bits. The transition *step* goes to ROUND.
- **ROUND**: the rounding increment is applied. The transition *step* goes to PACK.
- **PACK**: the range check, saturation and flag precedence are applied and the outputs are registered. The transition *finish* returns to IDLE and raises `done` for one cycle.

While the block is busy it ignores `go`. Between completions the outputs hold their values.

Top module: `f2i_convert`

## Requirements
- R1: `go` sampled high in IDLE starts a conversion. `done` is high for exactly one cycle, following the third rising edge after the edge that sampled `go`. A `go` sampled while a conversion is in progress is ignored.
- R2: Rounding mode encoding is 00 nearest with ties to even, 01 toward zero, 10 toward +infinity and 11 toward -infinity.
- R3: `truncate` high forces rounding toward zero whatever `rmode` holds.
- R4: `size_word` high selects a 32-bit destination and low selects 64 bits. `is_unsigned` selects an unsigned range. A word result is sign-extended (signed) or zero-extended (unsigned) into the 64-bit output.
- R5: A rounded value outside the destination range gives `invalid`=1 and `inexact`=0. A positive value saturates to the largest destination value. A negative value saturates to the smallest destination value, which is zero for unsigned.
- R6: The range check uses the value after rounding. For example, 2147483647.5 to a signed word overflows under nearest-even but not under toward-zero.
- R7: An unsigned conversion of a negative input that rounds to zero returns 0 with `inexact`=1 and `invalid`=0. If it rounds to a nonzero magnitude, the result is 0 with `invalid`=1.
- R8: A NaN input gives `invalid`=1, `inexact`=0, and returns the most negative signed value (sign-extended for a word) or 0 when unsigned. Infinities saturate as in R5.
- R9: `inexact` is 1 exactly when a discarded fraction bit is nonzero and no invalid condition applies. Exact conversions, zeros and negative zero raise no flag.
- R10: After reset `result`, `inexact`, `invalid` and `done` are 0.
- R11: `result` and the flags keep their values from one completion to the next, regardless of input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe, honoured in IDLE only |
| operand | input | 64 | Floating-point source value |
| size_word | input | 1 | 1 = 32-bit destination, 0 = 64-bit |
| is_unsigned | input | 1 | 1 = unsigned destination |
| truncate | input | 1 | 1 = force rounding toward zero |
| rmode | input | 2 | Rounding mode, encoded per R2 |
| result | output | 64 | Integer result, extended per R4 |
| inexact | output | 1 | Inexact flag |
| invalid | output | 1 | Invalid-conversion flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent, a 52-bit fraction, a 64-bit integer width and a 32-bit word width. These defaults make every destination boundary reachable with exactly representable operands. Examples are 2147483647.5, -2147483648.5, 4294967295.5 and 1e19, which sit on either side of the word and doubleword limits, along with subnormal operands, NaN and infinities. Each boundary value is driven under several rounding modes so that the rounding-before-range ordering and the flag precedence are both observed at the ports.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_POS  = 2'b10,
        RM_NEG  = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ALIGN = 2'd1,
        S_ROUND = 2'd2,
        S_PACK  = 2'd3
    } cvt_state_e;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [FP_W-1:0]   fp_in,
    output logic              sign,
    output logic [EXP_W-1:0]  exp_f,
    output logic [FRAC_W-1:0] frac,
    output logic              is_nan,
    output logic              is_special
);
    always_comb begin
        sign       = fp_in[FP_W-1];
        exp_f      = fp_in[FP_W-2 -: EXP_W];
        frac       = fp_in[FRAC_W-1:0];
        // all-ones exponent: infinity or NaN
        is_special = &exp_f;
        is_nan     = is_special && (|frac);
    end
endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64
) (
    input  logic [EXP_W-1:0]  exp_f,
    input  logic [FRAC_W-1:0] frac,
    input  logic              is_special,
    output logic [INT_W-1:0]  mag,
    output logic              guard,
    output logic              sticky,
    output logic              big
);
    localparam int MANT_W = FRAC_W + 1;
    localparam int WIDE_W = INT_W - 1 + MANT_W;
    localparam int SH_W   = $clog2(INT_W);
    localparam int EW     = EXP_W + 2;
    localparam logic signed [EW-1:0] BIAS  = EW'((1 << (EXP_W - 1)) - 1);
    localparam logic signed [EW-1:0] E_M1  = -EW'(1);
    localparam logic signed [EW-1:0] E_LIM = EW'(INT_W);

    logic signed [EW-1:0] e_unb;
    logic [WIDE_W-1:0]    wide;

    assign e_unb = $signed({2'b00, exp_f}) - BIAS;

    always_comb begin
        mag    = '0;
        guard  = 1'b0;
        sticky = 1'b0;
        big    = 1'b0;
        wide   = '0;
        if (is_special) begin
            big = 1'b1;
        end else if (exp_f == '0) begin
            // zero or subnormal: whole value lies below one half
            sticky = |frac;
        end else if (e_unb < E_M1) begin
            sticky = 1'b1;
        end else if (e_unb == E_M1) begin
            guard  = 1'b1;
            sticky = |frac;
        end else if (e_unb >= E_LIM) begin
            big = 1'b1;
        end else begin
            wide   = {{(INT_W-1){1'b0}}, 1'b1, frac} << e_unb[SH_W-1:0];
            mag    = wide[WIDE_W-1 -: INT_W];
            guard  = wide[FRAC_W-1];
            sticky = |wide[FRAC_W-2:0];
        end
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
#(
    parameter int INT_W = 64
) (
    input  logic [INT_W-1:0] mag,
    input  logic             guard,
    input  logic             sticky,
    input  logic             sign,
    input  rmode_e           rm,
    output logic [INT_W:0]   mag_r,
    output logic             lost
);
    logic inc;

    always_comb begin
        unique case (rm)
            RM_NEAR: inc = guard && (sticky || mag[0]);
            RM_ZERO: inc = 1'b0;
            RM_POS:  inc = !sign && (guard || sticky);
            RM_NEG:  inc = sign && (guard || sticky);
            default: inc = 1'b0;
        endcase
        lost  = guard || sticky;
        mag_r = {1'b0, mag} + {{INT_W{1'b0}}, inc};
    end
endmodule

// File: rtl/f2i_range.sv
module f2i_range #(
    parameter int INT_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic [INT_W:0]   mag_r,
    input  logic             sign,
    input  logic             big,
    input  logic             nan,
    input  logic             lost,
    input  logic             word,
    input  logic             uns,
    output logic [INT_W-1:0] res,
    output logic             inx,
    output logic             inv
);
    // index 0 = full width destination, index 1 = word destination
    logic [INT_W:0]   lim_pos_s [2];
    logic [INT_W:0]   lim_pos_u [2];
    logic [INT_W:0]   lim_neg_s [2];
    logic [INT_W-1:0] max_s     [2];
    logic [INT_W-1:0] max_u     [2];
    logic [INT_W-1:0] min_s     [2];

    for (genvar g = 0; g < 2; g++) begin : g_size
        localparam int DW = (g == 0) ? INT_W : WORD_W;
        assign lim_pos_u[g] = {{(INT_W + 1 - DW){1'b0}}, {DW{1'b1}}};
        assign lim_pos_s[g] = {{(INT_W + 2 - DW){1'b0}}, {(DW - 1){1'b1}}};
        assign lim_neg_s[g] = lim_pos_s[g] + 1'b1;
        assign max_s[g]     = lim_pos_s[g][INT_W-1:0];
        assign max_u[g]     = lim_pos_u[g][INT_W-1:0];
        assign min_s[g]     = ~lim_pos_s[g][INT_W-1:0];
    end

    logic sel;
    logic over;
    logic [INT_W-1:0] low_min;

    always_comb begin
        sel     = word;
        low_min = uns ? '0 : min_s[sel];
        if (big)
            over = 1'b1;
        else if (!sign)
            over = mag_r > (uns ? lim_pos_u[sel] : lim_pos_s[sel]);
        else
            over = mag_r > (uns ? '0 : lim_neg_s[sel]);

        inv = nan || over;
        inx = lost && !inv;

        if (nan)
            res = low_min;
        else if (over)
            res = sign ? low_min : (uns ? max_u[sel] : max_s[sel]);
        else if (sign)
            res = '0 - mag_r[INT_W-1:0];
        else
            res = mag_r[INT_W-1:0];
    end
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64,
    parameter int WORD_W = 32,
    localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [FP_W-1:0]   operand,
    input  logic              size_word,
    input  logic              is_unsigned,
    input  logic              truncate,
    input  logic [1:0]        rmode,
    output logic [INT_W-1:0]  result,
    output logic              inexact,
    output logic              invalid,
    output logic              done
);
    cvt_state_e state_q, state_d;

    // captured request
    logic [FP_W-1:0] op_q;
    logic            word_q, uns_q;
    rmode_e          rm_q;

    // ALIGN stage registers
    logic             al_sign, al_nan, al_big, al_guard, al_sticky;
    logic [INT_W-1:0] al_mag;

    // ROUND stage registers
    logic             rd_sign, rd_nan, rd_big, rd_lost;
    logic [INT_W:0]   rd_mag;

    // combinational stage outputs
    logic              u_sign, u_nan, u_special;
    logic [EXP_W-1:0]  u_exp;
    logic [FRAC_W-1:0] u_frac;
    logic [INT_W-1:0]  a_mag;
    logic              a_guard, a_sticky, a_big;
    logic [INT_W:0]    r_mag;
    logic              r_lost;
    logic [INT_W-1:0]  p_res;
    logic              p_inx, p_inv;

    f2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .fp_in(op_q), .sign(u_sign), .exp_f(u_exp), .frac(u_frac),
        .is_nan(u_nan), .is_special(u_special)
    );

    f2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
        .exp_f(u_exp), .frac(u_frac), .is_special(u_special),
        .mag(a_mag), .guard(a_guard), .sticky(a_sticky), .big(a_big)
    );

    f2i_round #(.INT_W(INT_W)) u_round (
        .mag(al_mag), .guard(al_guard), .sticky(al_sticky), .sign(al_sign),
        .rm(rm_q), .mag_r(r_mag), .lost(r_lost)
    );

    f2i_range #(.INT_W(INT_W), .WORD_W(WORD_W)) u_range (
        .mag_r(rd_mag), .sign(rd_sign), .big(rd_big), .nan(rd_nan),
        .lost(rd_lost), .word(word_q), .uns(uns_q),
        .res(p_res), .inx(p_inx), .inv(p_inv)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, step, step, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (go) state_d = S_ALIGN;
            S_ALIGN: state_d = S_ROUND;
            S_ROUND: state_d = S_PACK;
            S_PACK:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= '0;
            word_q    <= 1'b0;
            uns_q     <= 1'b0;
            rm_q      <= RM_NEAR;
            al_sign   <= 1'b0;
            al_nan    <= 1'b0;
            al_big    <= 1'b0;
            al_guard  <= 1'b0;
            al_sticky <= 1'b0;
            al_mag    <= '0;
            rd_sign   <= 1'b0;
            rd_nan    <= 1'b0;
            rd_big    <= 1'b0;
            rd_lost   <= 1'b0;
            rd_mag    <= '0;
            result    <= '0;
            inexact   <= 1'b0;
            invalid   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= (state_q == S_PACK);
            unique case (state_q)
                S_IDLE: if (go) begin
                    op_q   <= operand;
                    word_q <= size_word;
                    uns_q  <= is_unsigned;
                    rm_q   <= truncate ? RM_ZERO : rmode_e'(rmode);
                end
                S_ALIGN: begin
                    al_sign   <= u_sign;
                    al_nan    <= u_nan;
                    al_big    <= a_big;
                    al_guard  <= a_guard;
                    al_sticky <= a_sticky;
                    al_mag    <= a_mag;
                end
                S_ROUND: begin
                    rd_sign <= al_sign;
                    rd_nan  <= al_nan;
                    rd_big  <= al_big;
                    rd_lost <= r_lost;
                    rd_mag  <= r_mag;
                end
                S_PACK: begin
                    result  <= p_res;
                    inexact <= p_inx;
                    invalid <= p_inv;
                end
                default: ;
            endcase
        end
    end

    localparam int HI_W = INT_W - WORD_W + 1;
    logic [HI_W-1:0] hi_bits;
    assign hi_bits = result[INT_W-1:WORD_W-1];

    assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (go && state_q == S_IDLE) |=> ##3 done);

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_go_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(op_q));

    assert_word_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && word_q) |->
            (uns_q ? (hi_bits[HI_W-1:1] == '0) : ((&hi_bits) || !(|hi_bits))));

    assert_flag_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(inexact && invalid));

    assert_nan_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_nan) |-> (invalid && !inexact));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_PACK) |=> $stable(result));

endmodule

// File: tb/test_f2i_convert.sv
module test_f2i_convert;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [63:0] operand = '0;
    logic        size_word = 1'b0;
    logic        is_unsigned = 1'b0;
    logic        truncate = 1'b0;
    logic [1:0]  rmode = 2'b00;
    logic [63:0] result;
    logic        inexact, invalid, done;

    int nvec = 0;
    int nbad = 0;
    bit finished = 1'b0;

    localparam logic [1:0] NE = 2'b00, TZ = 2'b01, UP = 2'b10, DN = 2'b11;
    localparam logic [63:0] QNAN = 64'h7FF8000000000000;
    localparam logic [63:0] PINF = 64'h7FF0000000000000;
    localparam logic [63:0] NINF = 64'hFFF0000000000000;
    localparam logic [63:0] SMIN_W = 64'hFFFFFFFF80000000;
    localparam logic [63:0] SMAX_W = 64'h000000007FFFFFFF;
    localparam logic [63:0] UMAX_W = 64'h00000000FFFFFFFF;
    localparam logic [63:0] SMIN_D = 64'h8000000000000000;
    localparam logic [63:0] SMAX_D = 64'h7FFFFFFFFFFFFFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    f2i_convert i_f2i_convert (
        .clk(clk), .rst_n(rst_n), .go(go), .operand(operand),
        .size_word(size_word), .is_unsigned(is_unsigned), .truncate(truncate),
        .rmode(rmode), .result(result), .inexact(inexact), .invalid(invalid),
        .done(done)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one conversion with done timing (R1) and result checks
    task automatic conv(input string tag, input logic [63:0] op, input bit w,
                        input bit u, input bit t, input logic [1:0] rm,
                        input logic [63:0] e_res, input bit e_inx, input bit e_inv);
        @(negedge clk);
        operand = op; size_word = w; is_unsigned = u; truncate = t; rmode = rm;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk({tag, " R1"}, "done early", 64'(done), 64'd0);
        repeat (2) @(negedge clk);
        chk({tag, " R1"}, "done early", 64'(done), 64'd0);
        @(negedge clk);
        chk({tag, " R1"}, "done", 64'(done), 64'd1);
        chk(tag, "result", result, e_res);
        chk(tag, "inexact", 64'(inexact), 64'(e_inx));
        chk(tag, "invalid", 64'(invalid), 64'(e_inv));
        @(negedge clk);
        chk({tag, " R1"}, "done pulse", 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        chk("R10", "result", result, 64'd0);
        chk("R10", "inexact", 64'(inexact), 64'd0);
        chk("R10", "invalid", 64'(invalid), 64'd0);
        chk("R10", "done", 64'(done), 64'd0);
    endtask

    task automatic t_modes;
        conv("R2 ne 2.5", $realtobits(2.5), 0, 0, 0, NE, 64'd2, 1, 0);
        conv("R2 ne 3.5", $realtobits(3.5), 0, 0, 0, NE, 64'd4, 1, 0);
        conv("R2 ne 0.5", $realtobits(0.5), 0, 0, 0, NE, 64'd0, 1, 0);
        conv("R2 ne 1.5", $realtobits(1.5), 0, 0, 0, NE, 64'd2, 1, 0);
        conv("R2 ne -2.5", $realtobits(-2.5), 0, 0, 0, NE, -64'sd2, 1, 0);
        conv("R2 up 2.5", $realtobits(2.5), 0, 0, 0, UP, 64'd3, 1, 0);
        conv("R2 dn 2.5", $realtobits(2.5), 0, 0, 0, DN, 64'd2, 1, 0);
        conv("R2 dn -2.5", $realtobits(-2.5), 0, 0, 0, DN, -64'sd3, 1, 0);
        conv("R2 up -2.5", $realtobits(-2.5), 0, 0, 0, UP, -64'sd2, 1, 0);
        conv("R2 tz -2.5", $realtobits(-2.5), 0, 0, 0, TZ, -64'sd2, 1, 0);
    endtask

    task automatic t_truncate;
        conv("R3 trunc up 2.7", $realtobits(2.7), 0, 0, 1, UP, 64'd2, 1, 0);
        conv("R3 trunc dn -2.7", $realtobits(-2.7), 0, 0, 1, DN, -64'sd2, 1, 0);
        conv("R3 trunc ne 2.7", $realtobits(2.7), 1, 0, 1, NE, 64'd2, 1, 0);
    endtask

    task automatic t_sizes;
        conv("R4 sw -5", $realtobits(-5.0), 1, 0, 0, NE, 64'hFFFFFFFFFFFFFFFB, 0, 0);
        conv("R4 uw 3e9", $realtobits(3000000000.0), 1, 1, 0, NE, 64'h00000000B2D05E00, 0, 0);
        conv("R4 ud 1e19", $realtobits(1.0e19), 0, 1, 0, NE, 64'h8AC7230489E80000, 0, 0);
        conv("R4 sw min", $realtobits(-2147483648.0), 1, 0, 0, NE, SMIN_W, 0, 0);
    endtask

    task automatic t_saturate;
        conv("R5 sw 3e9", $realtobits(3000000000.0), 1, 0, 0, NE, SMAX_W, 0, 1);
        conv("R5 sw -3e9", $realtobits(-3000000000.0), 1, 0, 0, NE, SMIN_W, 0, 1);
        conv("R5 sd 1e19", $realtobits(1.0e19), 0, 0, 0, NE, SMAX_D, 0, 1);
        conv("R5 sd -1e19", $realtobits(-1.0e19), 0, 0, 0, NE, SMIN_D, 0, 1);
        conv("R5 uw 2^32", $realtobits(4294967296.0), 1, 1, 0, NE, UMAX_W, 0, 1);
        conv("R5 ud 1e20", $realtobits(1.0e20), 0, 1, 0, NE, 64'hFFFFFFFFFFFFFFFF, 0, 1);
    endtask

    task automatic t_round_then_range;
        conv("R6 sw ne max+.5", $realtobits(2147483647.5), 1, 0, 0, NE, SMAX_W, 0, 1);
        conv("R6 sw tz max+.5", $realtobits(2147483647.5), 1, 0, 1, NE, SMAX_W, 1, 0);
        conv("R6 sw ne min-.5", $realtobits(-2147483648.5), 1, 0, 0, NE, SMIN_W, 1, 0);
        conv("R6 sw dn min-.5", $realtobits(-2147483648.5), 1, 0, 0, DN, SMIN_W, 0, 1);
        conv("R6 uw up max+.5", $realtobits(4294967295.5), 1, 1, 0, UP, UMAX_W, 0, 1);
        conv("R6 uw dn max+.5", $realtobits(4294967295.5), 1, 1, 0, DN, UMAX_W, 1, 0);
    endtask

    task automatic t_unsigned_neg;
        conv("R7 uw ne -0.3", $realtobits(-0.3), 1, 1, 0, NE, 64'd0, 1, 0);
        conv("R7 ud ne -0.7", $realtobits(-0.7), 0, 1, 0, NE, 64'd0, 0, 1);
        conv("R7 uw tz -0.7", $realtobits(-0.7), 1, 1, 1, NE, 64'd0, 1, 0);
        conv("R7 ud ne -1", $realtobits(-1.0), 0, 1, 0, NE, 64'd0, 0, 1);
    endtask

    task automatic t_nan_inf;
        conv("R8 nan sd", QNAN, 0, 0, 0, NE, SMIN_D, 0, 1);
        conv("R8 nan uw", QNAN, 1, 1, 0, NE, 64'd0, 0, 1);
        conv("R8 nan sw", QNAN, 1, 0, 0, UP, SMIN_W, 0, 1);
        conv("R8 +inf sd", PINF, 0, 0, 0, NE, SMAX_D, 0, 1);
        conv("R8 -inf ud", NINF, 0, 1, 0, NE, 64'd0, 0, 1);
        conv("R8 -inf sw", NINF, 1, 0, 0, NE, SMIN_W, 0, 1);
    endtask

    task automatic t_exact;
        conv("R9 123", $realtobits(123.0), 0, 0, 0, UP, 64'd123, 0, 0);
        conv("R9 -0 unsigned", 64'h8000000000000000, 0, 1, 0, NE, 64'd0, 0, 0);
        conv("R9 2^60", $realtobits(1152921504606846976.0), 0, 0, 0, NE,
             64'h1000000000000000, 0, 0);
        conv("R9 subnormal up", 64'h0000000000000001, 0, 0, 0, UP, 64'd1, 1, 0);
        conv("R9 subnormal ne", 64'h0000000000000001, 0, 0, 0, NE, 64'd0, 1, 0);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        operand = $realtobits(7.0); size_word = 0; is_unsigned = 0;
        truncate = 0; rmode = NE; go = 1'b1;
        @(negedge clk);
        operand = $realtobits(99.0);     // go still high while busy
        @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 busy", "done", 64'(done), 64'd1);
        chk("R1 busy", "result", result, 64'd7);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 busy", "extra done", 64'(done), 64'd0);
        end
    endtask

    task automatic t_hold;
        conv("R11 setup", $realtobits(-0.3), 1, 1, 0, NE, 64'd0, 1, 0);
        operand = $realtobits(1.0e20); size_word = 0; is_unsigned = 1;
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk("R11 hold", "result", result, 64'd0);
        chk("R11 hold", "inexact", 64'(inexact), 64'd1);
        chk("R11 hold", "invalid", 64'(invalid), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_modes();
        t_truncate();
        t_sizes();
        t_saturate();
        t_round_then_range();
        t_unsigned_neg();
        t_nan_inf();
        t_exact();
        t_busy_ignore();
        t_hold();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule